// File: doc/BRIEF.md
# SIMD Lane Copy and Insert Unit

This block executes the element-move class of vector instructions against a file of 128-bit vector registers and a file of 64-bit general registers. Both register files sit outside the block. The unit decodes a 32-bit instruction word and drives combinational read addresses into both files. One cycle after a valid strobe it returns a registered write request: either a whole new 128-bit vector value or a 64-bit general register value.

Five move forms are supported:
- broadcast a vector element to every lane;
- broadcast a general register to every lane;
- insert one element taken from another vector;
- insert one element taken from a general register;
- extract one element to a general register.

Elements are 32 or 64 bits wide. The element size and the destination lane index are both taken from a single 5-bit selector field. An insert only replaces one lane. For that reason the unit also reads the current destination vector, and it writes back the merged 128-bit value. Any encoding outside the supported set raises a one-cycle unimplemented pulse instead of a write.

Top module: `simd_lane_mover`

## Requirements
- R1: Instruction fields sit at fixed bit positions:
  - Q is bit 30 and op is bit 29.
  - The 5-bit size selector is bits 20:16 and the 4-bit source index field is bits 14:11.
  - The source register number is bits 9:5 and the destination register number is bits 4:0.
  - A selector ending in binary 100 means 32-bit elements, with lane index = selector[4:3].
  - A selector ending in binary 1000 means 64-bit elements, with lane index = selector[4].
- R2: Extract is op=0 with source index field 7.
  - With Q=0 and 32-bit elements, the selected lane is written zero-extended to general register rd.
  - With Q=1 and 64-bit elements, the selected 64-bit lane is written.
  - A Q value that does not match the element size is unimplemented.
- R3: With Q=1, op=0 and field 0, the selected source element is copied into every lane of vd: four lanes for 32-bit elements, two for 64-bit.
- R4: With Q=1, op=0 and field 3, only lane selector-index of vd is replaced. The new value is the low 32 bits of the general register (32-bit elements) or all 64 bits (64-bit elements).
- R5: With Q=1, op=0 and field 1, the low 32 bits or all 64 bits of the general register are copied into every lane of vd.
- R6: With Q=1 and op=1, a source element goes into vd lane selector-index. The source lane index is field[3:2] for 32-bit elements and field[3] for 64-bit elements.
- R7: General register 31 reads as zero. A write addressed to general register 31 is dropped: no write enable and no unimplemented flag.
- R8: The following raise the unimplemented flag for one cycle with both write enables low:
  - a selector meaning 8-bit or 16-bit elements, or ending in 0000;
  - any field/Q/op combination not listed above.
- R9: Results and enables appear exactly one cycle after a valid strobe, as single-cycle pulses. Nothing is asserted without a preceding strobe, and reset clears all enables.
- R10: In an insert, the lanes of vd that are not selected keep their previous contents in the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| vecSrcAddr | output | 5 | Read address of the source vector (bits 9:5) |
| vecSrcData | input | 128 | Source vector contents |
| vecDstAddr | output | 5 | Read address of the destination vector (bits 4:0) |
| vecDstData | input | 128 | Current destination vector contents |
| gprRdAddr | output | 5 | Read address of the general register (bits 9:5) |
| gprRdData | input | 64 | General register contents |
| vecWrEn | output | 1 | Vector write request |
| vecWrAddr | output | 5 | Vector write address |
| vecWrData | output | 128 | Full vector value to write |
| gprWrEn | output | 1 | General register write request |
| gprWrAddr | output | 5 | General register write address |
| gprWrData | output | 64 | General register value to write |
| unimpl | output | 1 | Unimplemented encoding pulse |

## Verification
The bench targets index extraction at the extremes of the selector:
- the top 32-bit lane and the upper 64-bit lane, where a wrong shift would pick lane 0 or a shifted copy;
- the split between the destination index and the source index in element-to-element insert, which a swapped decode turns into the wrong lane moving.

General register 31 is used both as a source and as a destination. An unguarded design would either broadcast the file's real register 31 or issue a write to it.

Byte, halfword and mismatched-Q encodings must produce a flag with no write. A lax decoder would instead write some partial value.

// File: rtl/simd_lane_mover_pkg.sv
package simd_lane_mover_pkg;
  localparam int VEC_W    = 128;
  localparam int GPR_W    = 64;
  localparam int ELEM_S_W = 32;
  localparam int ELEM_D_W = 64;
  localparam int LANES_S  = VEC_W / ELEM_S_W;
  localparam int LANES_D  = VEC_W / ELEM_D_W;
  localparam int REG_AW   = 5;
  localparam int IDX_W    = $clog2(LANES_S);

  typedef struct packed {
    logic             doVecWr;
    logic             doGprWr;
    logic             badOp;
    logic             srcIsGpr;
    logic             fillAll;
    logic             wide;
    logic [IDX_W-1:0] dstIdx;
    logic [IDX_W-1:0] srcIdx;
  } moveCtrl_t;
endpackage

// File: rtl/simd_lane_mover_ctrl.sv
module simd_lane_mover_ctrl
  import simd_lane_mover_pkg::*;
(
  input  logic [31:0] instr,
  output moveCtrl_t   ctrl
);
  logic       qBit, opBit;
  logic [4:0] selField;
  logic [3:0] idxField;
  logic       isS, isD;

  assign qBit     = instr[30];
  assign opBit    = instr[29];
  assign selField = instr[20:16];
  assign idxField = instr[14:11];
  assign isS      = (selField[2:0] == 3'b100);
  assign isD      = (selField[3:0] == 4'b1000);

  always_comb begin
    ctrl = '0;
    ctrl.wide = isD;
    ctrl.dstIdx = isD ? {1'b0, selField[4]} : selField[4:3];
    ctrl.srcIdx = ctrl.dstIdx;
    if (!(isS || isD)) begin
      ctrl.badOp = 1'b1;
    end else if (!opBit && idxField == 4'd7) begin
      if ((qBit && isD) || (!qBit && isS)) ctrl.doGprWr = 1'b1;
      else ctrl.badOp = 1'b1;
    end else if (qBit && !opBit && idxField == 4'd0) begin
      ctrl.doVecWr = 1'b1;
      ctrl.fillAll = 1'b1;
    end else if (qBit && !opBit && idxField == 4'd3) begin
      ctrl.doVecWr  = 1'b1;
      ctrl.srcIsGpr = 1'b1;
    end else if (qBit && !opBit && idxField == 4'd1) begin
      ctrl.doVecWr  = 1'b1;
      ctrl.srcIsGpr = 1'b1;
      ctrl.fillAll  = 1'b1;
    end else if (qBit && opBit) begin
      ctrl.doVecWr = 1'b1;
      ctrl.srcIdx  = isD ? {1'b0, idxField[3]} : idxField[3:2];
    end else begin
      ctrl.badOp = 1'b1;
    end
  end
endmodule

// File: rtl/simd_lane_mover_dp.sv
module simd_lane_mover_dp
  import simd_lane_mover_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  moveCtrl_t         ctrl,
  input  logic [REG_AW-1:0] dstReg,
  input  logic [VEC_W-1:0]  vecSrcData,
  input  logic [VEC_W-1:0]  vecDstData,
  input  logic [GPR_W-1:0]  gprVal,
  output logic              vecWrEn,
  output logic [REG_AW-1:0] vecWrAddr,
  output logic [VEC_W-1:0]  vecWrData,
  output logic              gprWrEn,
  output logic [REG_AW-1:0] gprWrAddr,
  output logic [GPR_W-1:0]  gprWrData,
  output logic              unimpl
);
  logic [ELEM_S_W-1:0] lanesS [LANES_S];
  logic [ELEM_D_W-1:0] lanesD [LANES_D];
  logic [ELEM_D_W-1:0] elem;
  logic [VEC_W-1:0]    merged;

  genvar gi;
  generate
    for (gi = 0; gi < LANES_S; gi++) begin : gSplitS
      assign lanesS[gi] = vecSrcData[gi*ELEM_S_W +: ELEM_S_W];
    end
    for (gi = 0; gi < LANES_D; gi++) begin : gSplitD
      assign lanesD[gi] = vecSrcData[gi*ELEM_D_W +: ELEM_D_W];
    end
  endgenerate

  always_comb begin
    if (ctrl.srcIsGpr)
      elem = ctrl.wide ? gprVal : {{(ELEM_D_W-ELEM_S_W){1'b0}}, gprVal[ELEM_S_W-1:0]};
    else if (ctrl.wide)
      elem = lanesD[ctrl.srcIdx[0]];
    else
      elem = {{(ELEM_D_W-ELEM_S_W){1'b0}}, lanesS[ctrl.srcIdx]};
  end

  generate
    for (gi = 0; gi < LANES_S; gi++) begin : gMerge
      localparam int HALF = gi % (ELEM_D_W / ELEM_S_W);
      logic hit;
      assign hit = ctrl.fillAll ||
                   (ctrl.wide ? (ctrl.dstIdx[0] == 1'(gi / (ELEM_D_W / ELEM_S_W)))
                              : (ctrl.dstIdx == IDX_W'(gi)));
      assign merged[gi*ELEM_S_W +: ELEM_S_W] =
        !hit ? vecDstData[gi*ELEM_S_W +: ELEM_S_W] :
        ctrl.wide ? elem[HALF*ELEM_S_W +: ELEM_S_W] : elem[ELEM_S_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecWrEn   <= 1'b0;
      gprWrEn   <= 1'b0;
      unimpl    <= 1'b0;
      vecWrAddr <= '0;
      gprWrAddr <= '0;
      vecWrData <= '0;
      gprWrData <= '0;
    end else begin
      vecWrEn <= valid && ctrl.doVecWr;
      gprWrEn <= valid && ctrl.doGprWr && (dstReg != '1);
      unimpl  <= valid && ctrl.badOp;
      if (valid) begin
        vecWrAddr <= dstReg;
        gprWrAddr <= dstReg;
        vecWrData <= merged;
        gprWrData <= elem;
      end
    end
  end
endmodule

// File: rtl/simd_lane_mover.sv
module simd_lane_mover
  import simd_lane_mover_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                valid,
  input  logic [31:0]         instr,
  output logic [REG_AW-1:0]   vecSrcAddr,
  input  logic [VEC_W-1:0]    vecSrcData,
  output logic [REG_AW-1:0]   vecDstAddr,
  input  logic [VEC_W-1:0]    vecDstData,
  output logic [REG_AW-1:0]   gprRdAddr,
  input  logic [GPR_W-1:0]    gprRdData,
  output logic                vecWrEn,
  output logic [REG_AW-1:0]   vecWrAddr,
  output logic [VEC_W-1:0]    vecWrData,
  output logic                gprWrEn,
  output logic [REG_AW-1:0]   gprWrAddr,
  output logic [GPR_W-1:0]    gprWrData,
  output logic                unimpl
);
  moveCtrl_t ctrl;
  logic [GPR_W-1:0] gprVal;

  assign vecSrcAddr = instr[9:5];
  assign vecDstAddr = instr[4:0];
  assign gprRdAddr  = instr[9:5];
  assign gprVal     = (instr[9:5] == '1) ? '0 : gprRdData;

  simd_lane_mover_ctrl uCtrl (
    .instr (instr),
    .ctrl  (ctrl)
  );

  simd_lane_mover_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .valid      (valid),
    .ctrl       (ctrl),
    .dstReg     (instr[4:0]),
    .vecSrcData (vecSrcData),
    .vecDstData (vecDstData),
    .gprVal     (gprVal),
    .vecWrEn    (vecWrEn),
    .vecWrAddr  (vecWrAddr),
    .vecWrData  (vecWrData),
    .gprWrEn    (gprWrEn),
    .gprWrAddr  (gprWrAddr),
    .gprWrData  (gprWrData),
    .unimpl     (unimpl)
  );
endmodule

// File: rtl/simd_lane_mover_chk.sv
module simd_lane_mover_chk (
  input logic         clk,
  input logic         rstN,
  input logic         valid,
  input logic [31:0]  instr,
  input logic         vecWrEn,
  input logic [127:0] vecWrData,
  input logic         gprWrEn,
  input logic [4:0]   gprWrAddr,
  input logic [63:0]  gprWrData,
  input logic         unimpl
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({vecWrEn, gprWrEn, unimpl})); // R8

  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rstN)
    (vecWrEn || gprWrEn || unimpl) |-> $past(valid)); // R9

  AST_STROBE_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    (valid && instr[4:0] != 5'd31) |=> (vecWrEn || gprWrEn || unimpl)); // R9

  AST_ZR_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    gprWrEn |-> (gprWrAddr != 5'd31)); // R7

  AST_NARROW_EXTRACT_ZEXT: assert property (@(posedge clk) disable iff (!rstN)
    (gprWrEn && !$past(instr[30])) |-> (gprWrData[63:32] == 32'd0)); // R2

  AST_BCAST_LANES_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (vecWrEn && $past(instr[29] == 1'b0 && instr[14:11] == 4'd0 && instr[18:16] == 3'b100))
    |-> (vecWrData[127:96] == vecWrData[31:0] && vecWrData[95:64] == vecWrData[31:0]
         && vecWrData[63:32] == vecWrData[31:0])); // R3
endmodule

bind simd_lane_mover simd_lane_mover_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .valid     (valid),
  .instr     (instr),
  .vecWrEn   (vecWrEn),
  .vecWrData (vecWrData),
  .gprWrEn   (gprWrEn),
  .gprWrAddr (gprWrAddr),
  .gprWrData (gprWrData),
  .unimpl    (unimpl)
);

// File: tb/tb_simd_lane_mover.sv
module tb_simd_lane_mover;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [4:0]   vecSrcAddr, vecDstAddr, gprRdAddr, vecWrAddr, gprWrAddr;
  logic [127:0] vecSrcData, vecDstData, vecWrData;
  logic [63:0]  gprRdData, gprWrData;
  logic         vecWrEn, gprWrEn, unimpl;

  logic [127:0] vreg [32];
  logic [63:0]  greg [32];

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign vecSrcData = vreg[vecSrcAddr];
  assign vecDstData = vreg[vecDstAddr];
  assign gprRdData  = greg[gprRdAddr];

  simd_lane_mover dut (
    .clk(clk), .rstN(rstN), .valid(valid), .instr(instr),
    .vecSrcAddr(vecSrcAddr), .vecSrcData(vecSrcData),
    .vecDstAddr(vecDstAddr), .vecDstData(vecDstData),
    .gprRdAddr(gprRdAddr), .gprRdData(gprRdData),
    .vecWrEn(vecWrEn), .vecWrAddr(vecWrAddr), .vecWrData(vecWrData),
    .gprWrEn(gprWrEn), .gprWrAddr(gprWrAddr), .gprWrData(gprWrData),
    .unimpl(unimpl)
  );

  function automatic logic [31:0] mk(input logic q, input logic op, input logic [4:0] sel,
                                     input logic [3:0] fld, input logic [4:0] rn, input logic [4:0] rd);
    return {1'b0, q, op, 8'b01110000, sel, 1'b0, fld, 1'b1, rn, rd};
  endfunction

  function automatic logic [31:0] laneOf(input int r, input int k);
    return vreg[r][k*32 +: 32];
  endfunction

  task automatic checkVal(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishSim();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // drive one instruction, land on the negedge after the capturing edge
  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic expectVec(input string req, input logic [31:0] w, input logic [4:0] rd,
                           input logic [127:0] exp);
    issue(w);
    checkVal(req, {125'd0, vecWrEn, gprWrEn, unimpl}, 128'd4);
    checkVal(req, {123'd0, vecWrAddr}, {123'd0, rd});
    checkVal(req, vecWrData, exp);
    @(negedge clk);
    checkVal("R9", {125'd0, vecWrEn, gprWrEn, unimpl}, 128'd0);
  endtask

  task automatic expectGpr(input string req, input logic [31:0] w, input logic [4:0] rd,
                           input logic [63:0] exp);
    issue(w);
    checkVal(req, {125'd0, vecWrEn, gprWrEn, unimpl}, 128'd2);
    checkVal(req, {123'd0, gprWrAddr}, {123'd0, rd});
    checkVal(req, {64'd0, gprWrData}, {64'd0, exp});
    @(negedge clk);
    checkVal("R9", {125'd0, vecWrEn, gprWrEn, unimpl}, 128'd0);
  endtask

  task automatic expectBad(input string req, input logic [31:0] w);
    issue(w);
    checkVal(req, {125'd0, vecWrEn, gprWrEn, unimpl}, 128'd1);
    @(negedge clk);
    checkVal("R9", {125'd0, vecWrEn, gprWrEn, unimpl}, 128'd0);
  endtask

  task automatic testReset();
    checkVal("R9 reset", {125'd0, vecWrEn, gprWrEn, unimpl}, 128'd0);
  endtask

  task automatic testExtract();
    // R1 R2: 32-bit lane 3 (selector 11100), lane 1 (01100), 64-bit upper lane (11000)
    expectGpr("R2 ext32 lane3", mk(0, 0, 5'b11100, 4'd7, 5'd3, 5'd4), 5'd4, {32'd0, laneOf(3, 3)});
    expectGpr("R2 ext32 lane1", mk(0, 0, 5'b01100, 4'd7, 5'd3, 5'd4), 5'd4, {32'd0, laneOf(3, 1)});
    expectGpr("R2 ext64 hi", mk(1, 0, 5'b11000, 4'd7, 5'd3, 5'd5), 5'd5, vreg[3][127:64]);
    expectBad("R2 q mismatch", mk(0, 0, 5'b01000, 4'd7, 5'd3, 5'd5));
    expectBad("R2 q mismatch32", mk(1, 0, 5'b00100, 4'd7, 5'd3, 5'd5));
  endtask

  task automatic testBroadcastElem();
    expectVec("R3 dup32", mk(1, 0, 5'b10100, 4'd0, 5'd2, 5'd6), 5'd6, {4{laneOf(2, 2)}});
    expectVec("R3 dup64", mk(1, 0, 5'b01000, 4'd0, 5'd2, 5'd6), 5'd6, {2{vreg[2][63:0]}});
  endtask

  task automatic testInsertGpr();
    expectVec("R4 R10 ins32", mk(1, 0, 5'b11100, 4'd3, 5'd7, 5'd8), 5'd8,
              {greg[7][31:0], vreg[8][95:0]});
    expectVec("R4 R10 ins64", mk(1, 0, 5'b01000, 4'd3, 5'd7, 5'd8), 5'd8,
              {vreg[8][127:64], greg[7]});
  endtask

  task automatic testBroadcastGpr();
    expectVec("R5 dupg32", mk(1, 0, 5'b00100, 4'd1, 5'd7, 5'd9), 5'd9, {4{greg[7][31:0]}});
    expectVec("R5 dupg64", mk(1, 0, 5'b11000, 4'd1, 5'd7, 5'd9), 5'd9, {2{greg[7]}});
  endtask

  task automatic testInsertElem();
    // R6: dst lane 1, src lane 2 (field 1000)
    expectVec("R6 R10 insel32", mk(1, 1, 5'b01100, 4'b1000, 5'd10, 5'd11), 5'd11,
              {vreg[11][127:64], laneOf(10, 2), vreg[11][31:0]});
    // R6: dst lane 0, src lane 1
    expectVec("R6 R10 insel64", mk(1, 1, 5'b01000, 4'b1000, 5'd10, 5'd11), 5'd11,
              {vreg[11][127:64], vreg[10][127:64]});
  endtask

  task automatic testZeroReg();
    expectVec("R7 zr read", mk(1, 0, 5'b11000, 4'd1, 5'd31, 5'd12), 5'd12, 128'd0);
    issue(mk(1, 0, 5'b01000, 4'd7, 5'd3, 5'd31));
    checkVal("R7 zr write dropped", {125'd0, vecWrEn, gprWrEn, unimpl}, 128'd0);
  endtask

  task automatic testUnimpl();
    expectBad("R8 byte", mk(1, 0, 5'b00001, 4'd0, 5'd2, 5'd6));
    expectBad("R8 half", mk(1, 0, 5'b00010, 4'd0, 5'd2, 5'd6));
    expectBad("R8 sel10000", mk(1, 0, 5'b10000, 4'd0, 5'd2, 5'd6));
    expectBad("R8 q0 dup", mk(0, 0, 5'b00100, 4'd0, 5'd2, 5'd6));
    expectBad("R8 field5", mk(1, 0, 5'b00100, 4'd5, 5'd2, 5'd6));
    expectBad("R8 q0 op1", mk(0, 1, 5'b00100, 4'd0, 5'd2, 5'd6));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      for (int k = 0; k < 4; k++) vreg[i][k*32 +: 32] = 32'hA000_0000 + 32'(i * 16 + k);
      greg[i] = {32'hC0DE_0000 + 32'(i), 32'h5000_0000 + 32'(i)};
    end
    greg[31] = 64'hFFFF_EEEE_DDDD_CCCC;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testExtract();
    testBroadcastElem();
    testInsertGpr();
    testBroadcastGpr();
    testInsertElem();
    testZeroReg();
    testUnimpl();
    finishSim();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishSim();
  end
endmodule